// File: doc/BRIEF.md
# Accumulator Shift-Extract Unit

This unit takes one of several 64-bit accumulators, each held as a high word and a low word, and shifts the full 64-bit value arithmetically to the right. It then returns either a 32-bit word or a 16-bit halfword clamped to its signed range. The word forms can round to nearest before they drop the shifted-out bits, and one word form also saturates. The shift count comes from an instruction immediate or from the low bits of a general register. Bit 0 of the operation code selects the source.

When the unit accepts an operation, it registers the result and raises `out_valid_o` on the next cycle. Whenever a value does not fit its destination range, the unit also sends a one-cycle pulse on `ovf_set_o`. The owner of the control register ORs that pulse into sticky bit 23, and only that owner clears the bit. A two-state controller drives the output:
- `ST_IDLE` means no result is being presented.
- `ST_EMIT` means a fresh result is on the outputs.

The transitions are:
- ACCEPT: `ST_IDLE` to `ST_EMIT` when a valid, supported code arrives.
- CHAIN: `ST_EMIT` to `ST_EMIT` on a back-to-back accepted operation.
- DRAIN: `ST_EMIT` to `ST_IDLE` otherwise.
- WAIT: `ST_IDLE` to `ST_IDLE` otherwise.

Top module: `accx_unit`

## Requirements
- R1: While reset is asserted and right after it, `out_valid_o`, `ovf_set_o` and `result_o` are all zero.
- R2: `acc_idx_i` selects which accumulator is used. The 64-bit operand is {`acc_hi_i[idx]`, `acc_lo_i[idx]`}, with the high word in the upper half.
- R3: An operation is accepted when `valid_i` is high with a supported code. Its result and overflow pulse appear exactly one cycle later, together with `out_valid_o`. Back-to-back accepted operations give back-to-back results.
- R4: When `op_i[0]` is 1, the shift count is `reg_shift_i[4:0]`; the upper register bits and `imm_shift_i` are ignored. When `op_i[0]` is 0, the count is `imm_shift_i`.
- R5: Codes 0x00 and 0x01 (plain word) return bits [31:0] of the operand arithmetically shifted right by the count.
- R6: Codes 0x04 and 0x05 (rounded word) add the last bit shifted out to the shifted value and return bits [31:0] of the sum. For a count of 0, nothing is added.
- R7: In all word codes, `ovf_set_o` pulses when the shifted value is outside [-2^31, 2^31-1], either before or after the rounding increment. The plain codes also apply this after-increment test.
- R8: Codes 0x06 and 0x07 (rounded saturating word) return 0x7FFFFFFF when the rounded value is above 2^31-1 and 0x80000000 when it is below -2^31. Otherwise they return the same value as R6.
- R9: Codes 0x0E and 0x0F (halfword) return 0x00007FFF with an overflow pulse when the shifted value is above 32767. They return 0xFFFF8000 with a pulse when it is below -32768. Otherwise they return bits [31:0] of the shifted value with no pulse.
- R10: Any other code, and any cycle with `valid_i` low, produces no `out_valid_o` and no `ovf_set_o`, and leaves `result_o` unchanged.
- R11: `ovf_set_o` is high only while `out_valid_o` is high, and lasts a single cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 5 | Operation code; bit 0 selects the register shift source |
| acc_idx_i | input | IDX_W (2) | Accumulator index |
| imm_shift_i | input | SHIFT_W (5) | Immediate shift count |
| reg_shift_i | input | DATA_W (32) | Register value; its low SHIFT_W bits give the shift count |
| acc_hi_i | input | NUM_ACC x DATA_W | High words of all accumulators |
| acc_lo_i | input | NUM_ACC x DATA_W | Low words of all accumulators |
| result_o | output | DATA_W (32) | Registered extracted result |
| out_valid_o | output | 1 | Result is new this cycle |
| ovf_set_o | output | 1 | One-cycle pulse to set sticky control bit 23 |

## Verification
Every supported code is swept over all 32 shift counts and a set of accumulator values. The set includes zero, minus one, and both 64-bit extremes, which separate the arithmetic shift from a logical one. Values just beyond the word and halfword limits separate the pre-rounding and post-rounding overflow tests and the two clamp directions. One value is out of range before rounding but in range after it, and another crosses the limit only through rounding. A register shift with junk in its upper bits and an opposing immediate shows which source is used. Distinct contents in every accumulator slot expose a wrong index, and the unused codes confirm that nothing is emitted.

// File: rtl/accx_pkg.sv
package accx_pkg;

    // Function field of the operation code (bits [4:1]); bit 0 picks shift source
    localparam logic [3:0] FN_WORD = 4'h0;
    localparam logic [3:0] FN_RND  = 4'h2;
    localparam logic [3:0] FN_RSAT = 4'h3;
    localparam logic [3:0] FN_HSAT = 4'h7;

    typedef enum logic [1:0] {
        MODE_WORD,
        MODE_RND,
        MODE_RSAT,
        MODE_HSAT
    } accx_mode_e;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } accx_state_e;

endpackage

// File: rtl/accx_acc_mux.sv
module accx_acc_mux #(
    parameter int NUM_ACC = 4,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_ACC-1:0][DATA_W-1:0] hi_i,
    input  logic [NUM_ACC-1:0][DATA_W-1:0] lo_i,
    input  logic [IDX_W-1:0]               idx_i,
    output logic [2*DATA_W-1:0]            acc_o
);
    logic [NUM_ACC-1:0][2*DATA_W-1:0] joined;

    // Pair every high word with its low word
    for (genvar g = 0; g < NUM_ACC; g++) begin : g_join
        assign joined[g] = {hi_i[g], lo_i[g]};
    end

    assign acc_o = joined[idx_i];
endmodule

// File: rtl/accx_word_path.sv
module accx_word_path
    import accx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHIFT_W = 5
) (
    input  logic [2*DATA_W-1:0] acc_i,
    input  logic [SHIFT_W-1:0]  shamt_i,
    input  accx_mode_e          mode_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                ovf_o
);
    localparam int ACC_W = 2 * DATA_W;
    localparam int GW    = ACC_W + 1;
    localparam logic [DATA_W-1:0] SAT_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] SAT_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [GW-1:0]    guarded;   // shifted value with one guard bit below
    logic signed [ACC_W-1:0] rounded;   // shifted value plus guard bit
    logic                    pre_ovf;
    logic                    post_ovf;

    assign guarded = $signed({acc_i, 1'b0}) >>> shamt_i;
    assign rounded = guarded[GW-1:1] + {{(ACC_W-1){1'b0}}, guarded[0]};

    // In range when all bits from the word sign upward agree
    assign pre_ovf  = !((&guarded[GW-1:DATA_W]) || !(|guarded[GW-1:DATA_W]));
    assign post_ovf = !((&rounded[ACC_W-1:DATA_W-1]) || !(|rounded[ACC_W-1:DATA_W-1]));

    always_comb begin
        ovf_o = pre_ovf || post_ovf;
        unique case (mode_i)
            MODE_WORD: result_o = guarded[DATA_W:1];
            MODE_RND:  result_o = rounded[DATA_W-1:0];
            MODE_RSAT: begin
                if (post_ovf) result_o = rounded[ACC_W-1] ? SAT_NEG : SAT_POS;
                else          result_o = rounded[DATA_W-1:0];
            end
            default: begin
                result_o = '0;
                ovf_o    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/accx_half_path.sv
module accx_half_path #(
    parameter int DATA_W  = 32,
    parameter int SHIFT_W = 5
) (
    input  logic [2*DATA_W-1:0] acc_i,
    input  logic [SHIFT_W-1:0]  shamt_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                clamp_o
);
    localparam int ACC_W  = 2 * DATA_W;
    localparam int HALF_W = DATA_W / 2;
    localparam logic signed [ACC_W-1:0] H_MAX =
        {{(ACC_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] H_MIN =
        {{(ACC_W-HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] CLAMP_HI = {{(DATA_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] CLAMP_LO = {{(DATA_W-HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};

    logic signed [ACC_W-1:0] shifted;
    logic                    above;
    logic                    below;

    assign shifted = $signed(acc_i) >>> shamt_i;
    assign above   = shifted > H_MAX;
    assign below   = shifted < H_MIN;

    always_comb begin
        clamp_o = above || below;
        if (above)      result_o = CLAMP_HI;
        else if (below) result_o = CLAMP_LO;
        else            result_o = shifted[DATA_W-1:0];
    end
endmodule

// File: rtl/accx_unit.sv
module accx_unit
    import accx_pkg::*;
#(
    parameter int NUM_ACC = 4,
    parameter int DATA_W  = 32,
    parameter int SHIFT_W = 5,
    localparam int IDX_W  = $clog2(NUM_ACC)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          valid_i,
    input  logic [4:0]                    op_i,
    input  logic [IDX_W-1:0]              acc_idx_i,
    input  logic [SHIFT_W-1:0]            imm_shift_i,
    input  logic [DATA_W-1:0]             reg_shift_i,
    input  logic [NUM_ACC-1:0][DATA_W-1:0] acc_hi_i,
    input  logic [NUM_ACC-1:0][DATA_W-1:0] acc_lo_i,
    output logic [DATA_W-1:0]             result_o,
    output logic                          out_valid_o,
    output logic                          ovf_set_o
);
    localparam int HALF_W = DATA_W / 2;

    accx_state_e          state_q, state_nxt;
    accx_mode_e           mode_sel;
    logic                 op_known;
    logic                 fire;
    logic [3:0]           fn;
    logic [SHIFT_W-1:0]   shamt;
    logic [2*DATA_W-1:0]  acc_sel;
    logic [DATA_W-1:0]    word_res, half_res, sel_res;
    logic                 word_ovf, half_ovf, sel_ovf;
    logic [DATA_W-1:0]    result_q;
    logic                 ovf_q;
    logic                 unused_reg_hi;

    assign unused_reg_hi = ^reg_shift_i[DATA_W-1:SHIFT_W];

    // Decode
    assign fn    = op_i[4:1];
    assign shamt = op_i[0] ? reg_shift_i[SHIFT_W-1:0] : imm_shift_i;

    always_comb begin
        op_known = 1'b1;
        mode_sel = MODE_WORD;
        unique case (fn)
            FN_WORD: mode_sel = MODE_WORD;
            FN_RND:  mode_sel = MODE_RND;
            FN_RSAT: mode_sel = MODE_RSAT;
            FN_HSAT: mode_sel = MODE_HSAT;
            default: op_known = 1'b0;
        endcase
    end

    assign fire = valid_i && op_known;

    accx_acc_mux #(.NUM_ACC(NUM_ACC), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
        .hi_i (acc_hi_i),
        .lo_i (acc_lo_i),
        .idx_i(acc_idx_i),
        .acc_o(acc_sel)
    );

    accx_word_path #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_word (
        .acc_i   (acc_sel),
        .shamt_i (shamt),
        .mode_i  (mode_sel),
        .result_o(word_res),
        .ovf_o   (word_ovf)
    );

    accx_half_path #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_half (
        .acc_i   (acc_sel),
        .shamt_i (shamt),
        .result_o(half_res),
        .clamp_o (half_ovf)
    );

    assign sel_res = (mode_sel == MODE_HSAT) ? half_res : word_res;
    assign sel_ovf = (mode_sel == MODE_HSAT) ? half_ovf : word_ovf;

    // Next-state: ACCEPT / CHAIN on fire, DRAIN / WAIT otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_nxt = fire ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nxt = fire ? ST_EMIT : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            ovf_q    <= 1'b0;
        end else if (fire) begin
            result_q <= sel_res;
            ovf_q    <= sel_ovf;
        end else begin
            ovf_q    <= 1'b0;
        end
    end

    assign result_o    = result_q;
    assign out_valid_o = (state_q == ST_EMIT);
    assign ovf_set_o   = ovf_q;

    // R3
    emit_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid_o);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (!out_valid_o && !ovf_set_o && $stable(result_o)));

    // R11
    ovf_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set_o |-> out_valid_o);

    // R8
    rsat_extreme_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && ovf_set_o && $past(mode_sel) == MODE_RSAT) |->
        (result_o == {1'b0, {(DATA_W-1){1'b1}}} || result_o == {1'b1, {(DATA_W-1){1'b0}}}));

    // R9
    half_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && $past(mode_sel) == MODE_HSAT) |->
        ((&result_o[DATA_W-1:HALF_W-1]) || !(|result_o[DATA_W-1:HALF_W-1])));
endmodule

// File: tb/accx_unit_bench.sv
module accx_unit_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic              valid_i;
    logic [4:0]        op_i;
    logic [1:0]        acc_idx_i;
    logic [4:0]        imm_shift_i;
    logic [31:0]       reg_shift_i;
    logic [3:0][31:0]  acc_hi_i;
    logic [3:0][31:0]  acc_lo_i;
    logic [31:0]       result_o;
    logic              out_valid_o;
    logic              ovf_set_o;

    int n_chk  = 0;
    int n_fail = 0;

    accx_unit u_accx_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .acc_idx_i(acc_idx_i), .imm_shift_i(imm_shift_i), .reg_shift_i(reg_shift_i),
        .acc_hi_i(acc_hi_i), .acc_lo_i(acc_lo_i),
        .result_o(result_o), .out_valid_o(out_valid_o), .ovf_set_o(ovf_set_o)
    );

    localparam logic signed [65:0] W_MAX = 66'sd2147483647;
    localparam logic signed [65:0] W_MIN = -66'sd2147483648;
    localparam logic signed [65:0] H_MAX = 66'sd32767;
    localparam logic signed [65:0] H_MIN = -66'sd32768;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference from the requirement text
    task automatic model(input logic [63:0] a, input logic [4:0] op, input logic [4:0] sh,
                         output logic [31:0] res, output logic ovf);
        logic signed [65:0] s, q;
        logic rb, pre, post;
        s    = $signed({{2{a[63]}}, a}) >>> sh;
        rb   = (sh == 5'd0) ? 1'b0 : a[sh - 5'd1];
        q    = s + {65'd0, rb};
        pre  = (s > W_MAX) || (s < W_MIN);
        post = (q > W_MAX) || (q < W_MIN);
        case (op[4:1])
            4'h0: begin res = s[31:0]; ovf = pre || post; end
            4'h2: begin res = q[31:0]; ovf = pre || post; end
            4'h3: begin
                ovf = pre || post;
                if (q > W_MAX)      res = 32'h7FFFFFFF;
                else if (q < W_MIN) res = 32'h80000000;
                else                res = q[31:0];
            end
            default: begin
                if (s > H_MAX)      begin res = 32'h00007FFF; ovf = 1'b1; end
                else if (s < H_MIN) begin res = 32'hFFFF8000; ovf = 1'b1; end
                else                begin res = s[31:0];      ovf = 1'b0; end
            end
        endcase
    endtask

    function automatic string mode_tag(input logic [4:0] op);
        if (op[0]) return "R4";
        case (op[4:1])
            4'h0: return "R5";
            4'h2: return "R6";
            4'h3: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Load slot idx with a, other slots with distinct junk
    task automatic load_acc(input int idx, input logic [63:0] a);
        for (int k = 0; k < 4; k++) begin
            acc_hi_i[k] = ~a[63:32] ^ (32'h1111_1111 * (k + 1));
            acc_lo_i[k] = ~a[31:0]  ^ (32'h0F0F_0F0F + k);
        end
        acc_hi_i[idx] = a[63:32];
        acc_lo_i[idx] = a[31:0];
    endtask

    task automatic drive(input int idx, input logic [4:0] op, input logic [4:0] sh);
        valid_i     = 1'b1;
        op_i        = op;
        acc_idx_i   = 2'(idx);
        imm_shift_i = op[0] ? ~sh : sh;
        reg_shift_i = op[0] ? {27'h5ABCDEF, sh} : {27'h0, ~sh};
    endtask

    task automatic run_op(input int idx, input logic [4:0] op, input logic [4:0] sh,
                          input logic [63:0] a);
        logic [31:0] er;
        logic eo;
        @(negedge clk);
        load_acc(idx, a);
        drive(idx, op, sh);
        @(negedge clk);
        valid_i = 1'b0;
        model(a, op, sh, er, eo);
        check("R3 out_valid", {31'd0, out_valid_o}, 32'd1);
        check(mode_tag(op), result_o, er);
        check((op[4:1] == 4'h7) ? "R9 flag" : "R7 flag", {31'd0, ovf_set_o}, {31'd0, eo});
    endtask

    logic [63:0] pats [12];
    logic [4:0]  codes [8];

    initial begin
        pats[0]  = 64'h0000_0000_0000_0000;
        pats[1]  = 64'h0000_0000_1234_5678;
        pats[2]  = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[3]  = 64'h7FFF_FFFF_FFFF_FFFF;
        pats[4]  = 64'h8000_0000_0000_0000;
        pats[5]  = 64'h0000_0000_7FFF_FFFF;
        pats[6]  = 64'h0000_0000_FFFF_FFFF;
        pats[7]  = 64'hFFFF_FFFF_0000_0000;
        pats[8]  = 64'h0000_0000_0001_0000;
        pats[9]  = 64'hFFFF_FFFF_FFFF_7FFF;
        pats[10] = 64'h0000_0001_2345_6789;
        pats[11] = 64'hFFFF_FFFE_FFFF_FFFF;
        codes[0] = 5'h00; codes[1] = 5'h01; codes[2] = 5'h04; codes[3] = 5'h05;
        codes[4] = 5'h06; codes[5] = 5'h07; codes[6] = 5'h0E; codes[7] = 5'h0F;

        rst_n = 1'b0; valid_i = 1'b0; op_i = '0; acc_idx_i = '0;
        imm_shift_i = '0; reg_shift_i = '0; acc_hi_i = '0; acc_lo_i = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 out_valid", {31'd0, out_valid_o}, 32'd0);
        check("R1 ovf", {31'd0, ovf_set_o}, 32'd0);
        check("R1 result", result_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after release", {31'd0, out_valid_o}, 32'd0);

        // R2 each slot holds distinct contents
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            for (int j = 0; j < 4; j++) begin
                acc_hi_i[j] = 32'hA000_0000 + j;
                acc_lo_i[j] = 32'h0000_1000 * (j + 1);
            end
            drive(k, 5'h00, 5'd0);
            @(negedge clk);
            valid_i = 1'b0;
            check("R2 index", result_o, 32'h0000_1000 * (k + 1));
            check("R7 flag on R2 case", {31'd0, ovf_set_o}, 32'd1);
        end

        // Sweep: every code, every shift, every pattern
        for (int p = 0; p < 12; p++)
            for (int c = 0; c < 8; c++)
                for (int sh = 0; sh < 32; sh++)
                    run_op(p % 4, codes[c], 5'(sh), pats[p]);

        // R11 pulse is one cycle; R10 unsupported codes
        run_op(1, 5'h00, 5'd0, 64'h0000_0001_0000_0000);
        @(negedge clk);
        check("R11 pulse ends", {31'd0, ovf_set_o}, 32'd0);
        check("R11 valid ends", {31'd0, out_valid_o}, 32'd0);
        for (int c = 0; c < 32; c++) begin
            logic [31:0] held;
            if (c[4:1] == 4'h0 || c[4:1] == 4'h2 || c[4:1] == 4'h3 || c[4:1] == 4'h7) continue;
            held = result_o;
            @(negedge clk);
            load_acc(0, 64'h7FFF_0000_0000_1234);
            drive(0, 5'(c), 5'd3);
            @(negedge clk);
            valid_i = 1'b0;
            check("R10 no valid", {31'd0, out_valid_o}, 32'd0);
            check("R10 no flag", {31'd0, ovf_set_o}, 32'd0);
            check("R10 result held", result_o, held);
        end

        // R3 back-to-back (CHAIN)
        @(negedge clk);
        load_acc(2, 64'h0000_0000_0000_0100);
        drive(2, 5'h00, 5'd4);
        @(negedge clk);
        drive(2, 5'h00, 5'd8);
        check("R3 first of pair", result_o, 32'h10);
        check("R3 first valid", {31'd0, out_valid_o}, 32'd1);
        @(negedge clk);
        valid_i = 1'b0;
        check("R3 second of pair", result_o, 32'h1);
        check("R3 second valid", {31'd0, out_valid_o}, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule